// File: doc/BRIEF.md
# Timer Event Output Arbiter

This block owns a small register of event output bits that a multi-channel timer presents to the rest of the chip. Every timer channel may, in any cycle, ask for an action on any of the event bits. The action is one of clear, set, toggle or pulse. A software path can also force individual bits high or low through one-cycle set and clear strobes.

In each cycle the block resolves all requests aimed at each event bit on its own. A valid manual strobe wins outright. Otherwise the strongest channel action wins, ranked by action type and not by channel index. The result is registered, so the output changes one clock after the request. A pulse raises the bit for a single cycle. The bit falls again on the following cycle unless a new request arrives in that cycle.

Top module: `tmr_evt_arb`

## Requirements
- R1: While rst_ni is low, and after its release until the first request takes effect, every bit of ev_o is 0.
- R2: A manual set of an event, without a manual clear of the same event in the same cycle, makes that bit 1 on the next clock edge, whatever any channel requests.
- R3: A manual clear of an event, without a manual set of the same event in the same cycle, makes that bit 0 on the next clock edge, whatever any channel requests.
- R4: When manual set and clear hit the same event in the same cycle, both are discarded, and that event is resolved from the channel requests alone.
- R5: Channel c requests action on event e through the 3-bit field ch_req_i[(c*NUM_EV+e)*3 +: 3]: 000 none, 001 clear, 010 set, 011 toggle, 100 pulse. The codes 101 to 111 act as none. With no request, the bit keeps its value, except at the end of a pulse (R8).
- R6: Among the channel requests for the same event in the same cycle, the applied action is the highest ranked: clear, then set, then toggle, then pulse, whichever channels issue them.
- R7: A winning toggle inverts the bit's registered value on the next edge.
- R8: A winning pulse drives the bit to 1 for one cycle. On the cycle after, the bit returns to 0 if that event receives no request. Otherwise the new request is applied.
- R9: Each event bit is resolved independently. Requests and strobes for one event never change another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ch_req_i | input | NUM_CH*NUM_EV*3 | Packed channel action requests, one 3-bit field per channel and event |
| man_set_i | input | NUM_EV | Manual set strobes, one per event |
| man_clr_i | input | NUM_EV | Manual clear strobes, one per event |
| ev_o | output | NUM_EV | Registered event outputs |

## Verification
Assertions check three things on every cycle. A lone manual strobe forces its value on the next edge. Clear beats every other channel action in the selector. A toggle flips the bit, and a finished pulse with no follow-up falls to 0. Four behaviours appear only through the bench's scenarios: the full ranking between mixed channel actions, treatment of the reserved codes, independence between events, and a conflicting manual pair deferring to the channels. The bench checks these by comparing every bit on every clock against a behavioural model, both under directed sequences and under long random traffic.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int unsigned ACT_W = 3;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE = 3'b000,
    ACT_CLR  = 3'b001,
    ACT_SET  = 3'b010,
    ACT_TGL  = 3'b011,
    ACT_PLS  = 3'b100
  } evt_act_e;
endpackage

// File: rtl/tmr_evt_prio_sel.sv
module tmr_evt_prio_sel
  import tmr_evt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*ACT_W-1:0] req_i,
  output evt_act_e                act_o
);
  logic [NUM_CH-1:0] hit_clr, hit_set, hit_tgl, hit_pls;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ACT_W-1:0] code;
    assign code       = req_i[c*ACT_W +: ACT_W];
    assign hit_clr[c] = (code == ACT_CLR);
    assign hit_set[c] = (code == ACT_SET);
    assign hit_tgl[c] = (code == ACT_TGL);
    assign hit_pls[c] = (code == ACT_PLS);
  end

  // rank by action type, channel index irrelevant; reserved codes fall to none
  always_comb begin
    if      (|hit_clr) act_o = ACT_CLR;
    else if (|hit_set) act_o = ACT_SET;
    else if (|hit_tgl) act_o = ACT_TGL;
    else if (|hit_pls) act_o = ACT_PLS;
    else               act_o = ACT_NONE;
  end

  p_clr_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_clr) |-> (act_o == ACT_CLR));
  p_set_over_soft_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|hit_set) && !(|hit_clr)) |-> (act_o == ACT_SET));
endmodule

// File: rtl/tmr_evt_cell.sv
module tmr_evt_cell
  import tmr_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_act_e act_i,
  input  logic     man_set_i,
  input  logic     man_clr_i,
  output logic     ev_o
);
  logic ev_q, ev_d, pls_q, pls_d, man_ok;

  assign man_ok = man_set_i ^ man_clr_i;

  always_comb begin
    ev_d  = ev_q;
    pls_d = 1'b0;
    if (man_ok) begin
      ev_d = man_set_i;
    end else begin
      unique case (act_i)
        ACT_CLR: ev_d = 1'b0;
        ACT_SET: ev_d = 1'b1;
        ACT_TGL: ev_d = ~ev_q;
        ACT_PLS: begin
          ev_d  = 1'b1;
          pls_d = 1'b1;
        end
        default: if (pls_q) ev_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q  <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      ev_q  <= ev_d;
      pls_q <= pls_d;
    end
  end

  assign ev_o = ev_q;

  p_man_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (man_set_i && !man_clr_i) |=> ev_o);
  p_man_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (man_clr_i && !man_set_i) |=> !ev_o);
  p_conflict_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (man_set_i && man_clr_i && act_i == ACT_NONE && !pls_q) |=> $stable(ev_o));
  p_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!man_ok && act_i == ACT_TGL) |=> (ev_o != $past(ev_o)));
  p_pulse_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!man_ok && act_i == ACT_PLS) |=> ev_o);
  p_pulse_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pls_q && !man_ok && act_i == ACT_NONE) |=> !ev_o);
endmodule

// File: rtl/tmr_evt_arb.sv
module tmr_evt_arb
  import tmr_evt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned NUM_EV = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH*NUM_EV*ACT_W-1:0] ch_req_i,
  input  logic [NUM_EV-1:0]              man_set_i,
  input  logic [NUM_EV-1:0]              man_clr_i,
  output logic [NUM_EV-1:0]              ev_o
);
  localparam int unsigned EV_REQ_W = NUM_CH * ACT_W;

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    logic [EV_REQ_W-1:0] ev_req;
    evt_act_e            win_act;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_gather
      assign ev_req[c*ACT_W +: ACT_W] = ch_req_i[(c*NUM_EV+e)*ACT_W +: ACT_W];
    end

    tmr_evt_prio_sel #(.NUM_CH(NUM_CH)) i_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (ev_req),
      .act_o  (win_act)
    );

    tmr_evt_cell i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (win_act),
      .man_set_i (man_set_i[e]),
      .man_clr_i (man_clr_i[e]),
      .ev_o      (ev_o[e])
    );
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_low_r1: assert (ev_o == '0);
  end
endmodule

// File: tb/test_tmr_evt_arb.sv
module test_tmr_evt_arb;
  localparam int NCH = 4;
  localparam int NEV = 4;
  localparam int RW  = NCH*NEV*3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [RW-1:0] ch_req_i = '0;
  logic [NEV-1:0] man_set_i = '0, man_clr_i = '0;
  logic [NEV-1:0] ev_o;

  int tests = 0, fails = 0;
  bit exp_ev [NEV];
  bit exp_pls[NEV];
  string tag [NEV];

  tmr_evt_arb #(.NUM_CH(NCH), .NUM_EV(NEV)) i_tmr_evt_arb (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [RW-1:0] put(logic [RW-1:0] r, int c, int e, logic [2:0] a);
    r[(c*NEV+e)*3 +: 3] = a;
    return r;
  endfunction

  task automatic check_all();
    for (int e = 0; e < NEV; e++) begin
      tests++;
      if (ev_o[e] !== exp_ev[e]) begin
        fails++;
        $display("FAIL %s ev%0d actual=%0b expected=%0b", tag[e], e, ev_o[e], exp_ev[e]);
      end
    end
  endtask

  // check previous result, drive new inputs, predict next result
  task automatic step(logic [RW-1:0] r, logic [NEV-1:0] ms, logic [NEV-1:0] mc);
    @(negedge clk_i);
    check_all();
    ch_req_i = r; man_set_i = ms; man_clr_i = mc;
    for (int e = 0; e < NEV; e++) begin
      int best = 0;
      for (int c = 0; c < NCH; c++) begin
        int rank;
        case (r[(c*NEV+e)*3 +: 3])
          3'b001: rank = 4;
          3'b010: rank = 3;
          3'b011: rank = 2;
          3'b100: rank = 1;
          default: rank = 0;
        endcase
        if (rank > best) best = rank;
      end
      if (ms[e] != mc[e]) begin
        exp_ev[e] = ms[e]; exp_pls[e] = 0; tag[e] = ms[e] ? "R2" : "R3";
      end else begin
        tag[e] = (ms[e] && mc[e]) ? "R4" : "R6";
        case (best)
          4: exp_ev[e] = 0;
          3: exp_ev[e] = 1;
          2: begin exp_ev[e] = !exp_ev[e]; tag[e] = "R7"; end
          1: begin exp_ev[e] = 1; tag[e] = "R8"; end
          default: begin
            if (exp_pls[e]) begin exp_ev[e] = 0; tag[e] = "R8"; end
            else if (tag[e] != "R4") tag[e] = "R5";
          end
        endcase
        exp_pls[e] = (best == 1);
      end
    end
  endtask

  initial begin
    #(200000*20);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [RW-1:0] r;
    for (int e = 0; e < NEV; e++) begin exp_ev[e] = 0; exp_pls[e] = 0; tag[e] = "R1"; end
    repeat (3) @(negedge clk_i);
    check_all();                                   // R1 during reset
    rst_ni = 1'b1;
    step('0, '0, '0);                              // R1 after release
    // R2 manual set beats channel clear on ev0; R9 others untouched
    r = put('0, 0, 0, 3'b001);
    step(r, 4'b0001, 4'b0000);
    // R3 manual clear beats channel set on ev0
    r = put('0, 2, 0, 3'b010);
    step(r, 4'b0000, 4'b0001);
    // R4 conflicting manual pair, channel set applies on ev1
    r = put('0, 3, 1, 3'b010);
    step(r, 4'b0010, 4'b0010);
    // R4 conflicting pair with no channel request holds
    step('0, 4'b0010, 4'b0010);
    // R6 clear beats set/toggle/pulse on ev1
    r = put('0, 0, 1, 3'b100); r = put(r, 1, 1, 3'b011);
    r = put(r, 2, 1, 3'b010);  r = put(r, 3, 1, 3'b001);
    step(r, '0, '0);
    // R6 set beats toggle and pulse on ev2
    r = put('0, 3, 2, 3'b011); r = put(r, 0, 2, 3'b100); r = put(r, 1, 2, 3'b010);
    step(r, '0, '0);
    // R7 toggle ev2 and ev3
    r = put('0, 1, 2, 3'b011); r = put(r, 2, 3, 3'b011);
    step(r, '0, '0);
    step(r, '0, '0);
    // R5 reserved codes hold
    r = put('0, 0, 3, 3'b101); r = put(r, 1, 3, 3'b110); r = put(r, 2, 3, 3'b111);
    step(r, '0, '0);
    // R8 pulse then idle
    r = put('0, 1, 0, 3'b100);
    step(r, '0, '0);
    step('0, '0, '0);
    step('0, '0, '0);
    // R8 back-to-back pulses, then pulse followed by toggle
    step(r, '0, '0);
    step(r, '0, '0);
    step(put('0, 3, 0, 3'b011), '0, '0);
    step('0, '0, '0);
    // random traffic, all requirements
    for (int n = 0; n < 4000; n++) begin
      logic [RW-1:0] rr = '0;
      logic [NEV-1:0] ms = '0, mc = '0;
      for (int c = 0; c < NCH; c++)
        for (int e = 0; e < NEV; e++)
          if ($urandom_range(0, 3) == 0) rr = put(rr, c, e, 3'($urandom_range(0, 7)));
      for (int e = 0; e < NEV; e++) begin
        ms[e] = ($urandom_range(0, 7) == 0);
        mc[e] = ($urandom_range(0, 7) == 0);
      end
      step(rr, ms, mc);
    end
    step('0, '0, '0);
    @(negedge clk_i);
    check_all();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule